// File: doc/BRIEF.md
# Wrapping Burst Beat Sequencer

This block drives the data side of a 64-bit big-endian bus. A burst moves one 32-byte block as four double-word beats. It starts at the double word named by the address and wraps around the block, so the requested data comes first. A single-beat transfer carries a byte or a half-word. The block puts that operand on the byte lanes chosen by a 4-bit size code and the three low address bits.

A request is sampled when `start_i` is high and the block is idle. From the next cycle the block presents the beat index, the double-word select, the lane enables and the steered data. Each beat is held until the target raises `ack_i`. After the last acknowledged beat, `done_o` pulses and the block is idle again. A request the block cannot carry is refused with a one-cycle `misalign_o` pulse.

Address bits are numbered with `addr_i[0]` as the least significant bit. `addr_i[2:0]` is the byte offset inside a double word, and `addr_i[4:3]` is the double word inside the 32-byte block. Lane Bk (k = 0 to 7) is `data_o[63-8k -: 8]` and is enabled by `lane_en_o[7-k]`. B0 is the most significant byte.

Top module: `burst_beat_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `lane_en_o`, `data_o`, `beat_idx_o` and `dw_sel_o` are all zero, and `done_o` and `misalign_o` are low.
- R2: An accepted burst (`burst_i`=1, `addr_i[2:0]`=000) runs exactly four beats. Beat n has `beat_idx_o`=n and `dw_sel_o`=(`addr_i[4:3]`+n) mod 4, so a start of 2 gives the order 2,3,0,1.
- R3: During every burst beat, `lane_en_o`=8'hFF and `data_o` equals `wdata_i`.
- R4: A beat advances only on a cycle where `ack_i` is high. Without it, the beat index, the double-word select and the lanes hold.
- R5: A single transfer with size code 4'b0001 enables only lane Bk, where k=`addr_i[2:0]`. It places `wdata_i[7:0]` in that lane and drives zero on every other lane.
- R6: A single transfer with size code 4'b0010 at an even `addr_i[2:0]`=k enables lanes Bk and Bk+1. It places `wdata_i[15:8]` on Bk and `wdata_i[7:0]` on Bk+1, and drives zero elsewhere.
- R7: A request is refused if it is a half-word with `addr_i[0]`=1, a burst with a nonzero `addr_i[2:0]`, or a single transfer whose size code is neither 0001 nor 0010. A refused request raises `misalign_o` for exactly one cycle, in the cycle after `start_i` was sampled, and starts no transfer.
- R8: `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the fourth burst beat or of the only single beat. The block is idle in that same cycle.
- R9: A `start_i` that arrives while a transfer is in progress is ignored. The transfer in progress keeps its beat index and double-word select.
- R10: A single transfer shows `beat_idx_o`=0 and `dw_sel_o`=`addr_i[4:3]` for its one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| size_i | input | 4 | Size code for a single beat (0001 byte, 0010 half-word) |
| addr_i | input | 32 | Request address |
| wdata_i | input | 64 | Write data; operand right-justified for single beats |
| ack_i | input | 1 | Target acknowledge for the current beat |
| beat_idx_o | output | 2 | Index of the current beat |
| dw_sel_o | output | 2 | Double word addressed by the current beat |
| lane_en_o | output | 8 | Byte-lane enables, bit 7 = B0 |
| data_o | output | 64 | Lane-steered data |
| done_o | output | 1 | One-cycle pulse after the final acknowledged beat |
| misalign_o | output | 1 | One-cycle pulse for a refused request |

## Verification
A request sampled at clock edge k shows its first beat, or its refusal pulse, right after edge k. Each acknowledge sampled at an edge moves the outputs right after that same edge. `done_o` rises right after the edge that samples the final acknowledge. The bench changes inputs on falling edges and reads outputs on the next falling edge, so every check falls in the half cycle after the edge that produces the result. Stalls leave `ack_i` low for a whole cycle, and the bench then reads the outputs again to confirm they held.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam logic [3:0] SZ_BYTE = 4'b0001;
  localparam logic [3:0] SZ_HALF = 4'b0010;

  typedef enum logic {
    ST_IDLE,
    ST_XFER
  } seq_state_e;
endpackage

// File: rtl/bbs_req_check.sv
module bbs_req_check #(
  parameter int OFF_W = 3
) (
  input  logic             start_i,
  input  logic             idle_i,
  input  logic             burst_i,
  input  logic [3:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             accept_o,
  output logic             reject_o
);
  import bbs_pkg::*;

  logic bad;

  always_comb begin
    if (burst_i) begin
      bad = (off_i != '0);
    end else begin
      unique case (size_i)
        SZ_BYTE: bad = 1'b0;
        SZ_HALF: bad = off_i[0];
        default: bad = 1'b1;
      endcase
    end
  end

  assign accept_o = start_i && idle_i && !bad;
  assign reject_o = start_i && idle_i && bad;
endmodule

// File: rtl/bbs_beat_ctrl.sv
module bbs_beat_ctrl #(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             burst_i,
  input  logic [CNT_W-1:0] first_dw_i,
  input  logic             ack_i,
  output logic             active_o,
  output logic             burst_o,
  output logic [CNT_W-1:0] beat_o,
  output logic [CNT_W-1:0] dw_sel_o,
  output logic             done_o
);
  import bbs_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  seq_state_e       state_q;
  logic             burst_q;
  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] base_q;
  logic             done_q;
  logic             finish;

  // last acknowledged beat of the running transfer
  assign finish = (state_q == ST_XFER) && ack_i && (!burst_q || beat_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept_i) begin
        state_q <= ST_XFER;
        burst_q <= burst_i;
        beat_q  <= '0;
        base_q  <= first_dw_i;
      end else if (finish) begin
        state_q <= ST_IDLE;
        burst_q <= 1'b0;
        beat_q  <= '0;
        base_q  <= '0;
      end else if (state_q == ST_XFER && ack_i) begin
        beat_q <= beat_q + CNT_W'(1);
      end
    end
  end

  assign active_o = (state_q == ST_XFER);
  assign burst_o  = burst_q;
  assign beat_o   = beat_q;
  assign dw_sel_o = base_q + beat_q;
  assign done_o   = done_q;

  // R4
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !ack_i |=> active_o && $stable(beat_o) && $stable(dw_sel_o));

  // R2
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && burst_o && ack_i && beat_o != LAST |=>
      dw_sel_o == CNT_W'($past(dw_sel_o) + CNT_W'(1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o ##1 !done_o);
endmodule

// File: rtl/bbs_lane_steer.sv
module bbs_lane_steer #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [3:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              active_i,
  input  logic              burst_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DATA_W-1:0] data_o
);
  import bbs_pkg::*;

  logic             half_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      off_q  <= '0;
    end else if (capture_i) begin
      half_q <= (size_i == SZ_HALF);
      off_q  <= off_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * k;
    localparam logic [OFF_W-1:0] K = OFF_W'(k);
    logic       sel;
    logic [7:0] byte_src;

    always_comb begin
      if (burst_i) begin
        sel      = 1'b1;
        byte_src = wdata_i[HI -: 8];
      end else if (half_q) begin
        sel      = (off_q[OFF_W-1:1] == K[OFF_W-1:1]);
        byte_src = K[0] ? wdata_i[7:0] : wdata_i[15:8];
      end else begin
        sel      = (off_q == K);
        byte_src = wdata_i[7:0];
      end
    end

    assign lane_en_o[LANES-1-k] = active_i && sel;
    assign data_o[HI -: 8]      = (active_i && sel) ? byte_src : 8'h00;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> lane_en_o == '0 && data_o == '0);

  // R5
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !burst_i && !half_q |-> $countones(lane_en_o) == 1);

  // R6
  half_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !burst_i && half_q |-> $countones(lane_en_o) == 2);
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic [3:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [CNT_W-1:0]  beat_idx_o,
  output logic [CNT_W-1:0]  dw_sel_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              misalign_o
);
  logic accept, reject, active, burst_q, misalign_q;

  bbs_req_check #(.OFF_W(OFF_W)) u_check (
    .start_i  (start_i),
    .idle_i   (!active),
    .burst_i  (burst_i),
    .size_i   (size_i),
    .off_i    (addr_i[OFF_W-1:0]),
    .accept_o (accept),
    .reject_o (reject)
  );

  bbs_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .burst_i    (burst_i),
    .first_dw_i (addr_i[OFF_W +: CNT_W]),
    .ack_i      (ack_i),
    .active_o   (active),
    .burst_o    (burst_q),
    .beat_o     (beat_idx_o),
    .dw_sel_o   (dw_sel_o),
    .done_o     (done_o)
  );

  bbs_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .size_i    (size_i),
    .off_i     (addr_i[OFF_W-1:0]),
    .active_i  (active),
    .burst_i   (burst_q),
    .wdata_i   (wdata_i),
    .lane_en_o (lane_en_o),
    .data_o    (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) misalign_q <= 1'b0;
    else         misalign_q <= reject;
  end

  assign misalign_o = misalign_q;

  // R7
  refuse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !active && lane_en_o == '0);

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && start_i && !ack_i |=> $stable(dw_sel_o) && $stable(beat_idx_o) && !misalign_o);
endmodule

// File: tb/burst_beat_seq_test.sv
module burst_beat_seq_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        burst = 1'b0;
  logic [3:0]  size = 4'b0000;
  logic [31:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        ack = 1'b0;
  logic [1:0]  beat_idx, dw_sel;
  logic [7:0]  lane_en;
  logic [63:0] data;
  logic        done, misalign;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_beat_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .burst_i(burst),
    .size_i(size), .addr_i(addr), .wdata_i(wdata), .ack_i(ack),
    .beat_idx_o(beat_idx), .dw_sel_o(dw_sel), .lane_en_o(lane_en),
    .data_o(data), .done_o(done), .misalign_o(misalign)
  );

  typedef struct packed {
    logic [3:0]  sz;
    logic [2:0]  off;
    logic [15:0] opnd;
    logic [7:0]  exp_lane;
    logic [63:0] exp_data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0001, 3'd0, 16'h00A5, 8'h80, 64'hA500_0000_0000_0000},
    '{4'b0001, 3'd3, 16'h003C, 8'h10, 64'h0000_003C_0000_0000},
    '{4'b0001, 3'd5, 16'h00E1, 8'h04, 64'h0000_0000_00E1_0000},
    '{4'b0001, 3'd7, 16'h0077, 8'h01, 64'h0000_0000_0000_0077},
    '{4'b0010, 3'd0, 16'hBEEF, 8'hC0, 64'hBEEF_0000_0000_0000},
    '{4'b0010, 3'd2, 16'h1234, 8'h30, 64'h0000_1234_0000_0000},
    '{4'b0010, 3'd4, 16'h5A6B, 8'h0C, 64'h0000_0000_5A6B_0000},
    '{4'b0010, 3'd6, 16'hCAFE, 8'h03, 64'h0000_0000_0000_CAFE}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, {lane_en, beat_idx, dw_sel, done, misalign}, '0);
    chk(req, data, '0);
  endtask

  task automatic issue(input logic b, input logic [3:0] s, input logic [31:0] a);
    burst = b; size = s; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ack_beat();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic run_burst(input logic [1:0] first, input bit stall);
    wdata = {8'h11 + 8'(first), 56'h22_3344_5566_7788};
    issue(1'b1, 4'b0000, {27'd0, first, 3'b000});
    for (int b = 0; b < 4; b++) begin
      chk("R2 beat", 64'(beat_idx), 64'(b));
      chk("R2 dw order", 64'(dw_sel), 64'(2'(first + 2'(b))));
      chk("R3 lanes", 64'(lane_en), 64'hFF);
      chk("R3 data", data, wdata);
      if (stall) begin
        start = 1'b1; addr = 32'h0000_0018;  // R9 start during burst
        @(negedge clk);
        start = 1'b0;
        chk("R4 hold beat", 64'(beat_idx), 64'(b));
        chk("R9 dw unchanged", 64'(dw_sel), 64'(2'(first + 2'(b))));
        chk("R9 no refusal", 64'(misalign), 64'd0);
      end
      if (b < 3) chk("R8 no early done", 64'(done), 64'd0);
      ack_beat();
    end
    chk("R8 done", 64'(done), 64'd1);
    chk("R8 idle at done", 64'(lane_en), 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'd0);
    idle_chk("R1 after burst");
  endtask

  task automatic refuse(input logic b, input logic [3:0] s, input logic [2:0] off);
    wdata = '1;
    issue(b, s, {27'd0, 2'd2, off});
    chk("R7 refused", 64'(misalign), 64'd1);
    chk("R7 no transfer", 64'(lane_en), 64'd0);
    @(negedge clk);
    chk("R7 one cycle", 64'(misalign), 64'd0);
    idle_chk("R7 stays idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 after reset");

    foreach (VECS[i]) begin
      wdata = {48'hFFFF_FFFF_FFFF, VECS[i].opnd};
      issue(1'b0, VECS[i].sz, {27'd0, 2'd1, VECS[i].off});
      chk(VECS[i].sz == 4'b0001 ? "R5 lanes" : "R6 lanes", 64'(lane_en), 64'(VECS[i].exp_lane));
      chk(VECS[i].sz == 4'b0001 ? "R5 data" : "R6 data", data, VECS[i].exp_data);
      chk("R10 single beat", {62'd0, beat_idx}, 64'd0);
      chk("R10 single dw", {62'd0, dw_sel}, 64'd1);
      ack_beat();
      chk("R8 single done", 64'(done), 64'd1);
      @(negedge clk);
      idle_chk("R1 after single");
    end

    for (int f = 0; f < 4; f++) run_burst(2'(f), f == 2);

    // R4: single beat held without acknowledge
    wdata = 64'h0000_0000_0000_00C3;
    issue(1'b0, 4'b0001, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk("R4 single held", 64'(lane_en), 64'h20);
    chk("R4 no done", 64'(done), 64'd0);
    ack_beat();
    chk("R8 done after hold", 64'(done), 64'd1);
    @(negedge clk);

    refuse(1'b0, 4'b0010, 3'd1);
    refuse(1'b0, 4'b0010, 3'd7);
    refuse(1'b1, 4'b0000, 3'd4);
    refuse(1'b0, 4'b0100, 3'd0);

    // R1: reset mid-burst returns to idle
    issue(1'b1, 4'b0000, 32'h0000_0008);
    rst_n = 1'b0;
    #1;
    idle_chk("R1 reset mid burst");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule